// File: doc/BRIEF.md
# Rotating Priority Interrupt Arbitration Core

This core arbitrates among a parameterised number of interrupt lines (eight by default) for a single CPU interrupt output. It holds three registers: pending requests, masks and in-service lines. It also holds a rotating priority base. Each line is captured either on its level or on a rising edge, and the choice is made per line.

Every cycle the core searches the unmasked pending lines. The search starts at the base line and wraps around. The winner is compared against the in-service set, which is searched with the same rotation. The interrupt output is raised only when the winner is strictly more urgent than the most urgent in-service line.

An external command decoder drives the core through simple load strobes: mask, trigger select, base, mode bits, in-service clear and initialise. A one-cycle acknowledge pulse returns the granted line number and updates the in-service and request registers. Automatic end-of-interrupt, with optional rotation, is supported.

Top module: `rpic_core`

## Requirements
- R1: After synchronous reset, `irq_out`, `ack_hit`, `req_out`, `isr_out`, `mask_out`, `trig_out` and `base_out` are all zero.
- R2: A line whose trigger-select bit is 1 (level) has its request bit follow `irq_in` one clock later, high or low.
- R3: A line whose trigger-select bit is 0 (edge) sets its request bit when `irq_in` goes from low to high. The bit stays set after the input falls.
- R4: With priority base b, the candidate lines are ranked b, b+1, … modulo N. The first pending candidate in that order is the line returned on acknowledge.
- R5: The candidate set is `req & ~mask`. When it is empty, `irq_out` is 0 and an acknowledge grants nothing.
- R6: `irq_out` is 1 only when the candidate's rank is strictly better than the best in-service rank. Clearing in-service bits through `isr_clr_ld` with `isr_clr_val` lifts that block.
- R7: With special mask mode on, in-service bits that are masked are left out of the comparison.
- R8: With special nesting mode on in a master instance, in-service bit `CAS_LINE` (2 by default) is left out of the comparison.
- R9: An acknowledge that grants a line with auto-EOI off sets that line's in-service bit. The line number appears on `ack_line`, and `ack_hit` is 1, from the next cycle on.
- R10: With auto-EOI on, a grant leaves the in-service register unchanged. If rotate-on-auto-EOI is also on, the base becomes (line+1) mod N; otherwise the base is unchanged.
- R11: A grant clears the granted request bit only for an edge line. A level line keeps its request bit.
- R12: The trigger-select register loads `trig_val & TRIG_ALLOW` (0xF8 by default). `init` clears requests, mask, in-service, base and modes, but not the trigger-select register.
- R13: An acknowledge with no grantable line gives `ack_hit` = 0 and `ack_line` = N-1, and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | N | Interrupt request inputs |
| init | input | 1 | Controller initialise strobe (keeps trigger select) |
| mask_ld | input | 1 | Load mask register |
| mask_val | input | N | Mask value (1 = masked) |
| trig_ld | input | 1 | Load trigger-select register |
| trig_val | input | N | Trigger select value (1 = level, 0 = edge) |
| base_ld | input | 1 | Load priority base |
| base_val | input | W | Priority base value |
| mode_ld | input | 1 | Load the four mode bits |
| mode_smm | input | 1 | Special mask mode |
| mode_sfn | input | 1 | Special nesting mode (master only) |
| mode_aeoi | input | 1 | Automatic end of interrupt |
| mode_raeoi | input | 1 | Rotate on automatic end of interrupt |
| isr_clr_ld | input | 1 | Clear in-service bits |
| isr_clr_val | input | N | In-service bits to clear |
| ack | input | 1 | Acknowledge pulse |
| irq_out | output | 1 | Registered CPU interrupt request |
| ack_line | output | W | Line granted by the last acknowledge |
| ack_hit | output | 1 | Last acknowledge granted a line |
| req_out | output | N | Request register |
| isr_out | output | N | In-service register |
| mask_out | output | N | Mask register |
| trig_out | output | N | Trigger-select register |
| base_out | output | W | Priority base |

## Verification
A corrupted request, mask or base register changes which line `ack_line` names. It can also make `irq_out` rise with no unmasked request pending; both show up within two cycles of the stimulus.

A wrong in-service bit shows up as a missing or extra `irq_out` as soon as a line of equal or lower rank is pending. The sweep over every base and many request and mask patterns therefore exposes rotation and masking faults on the first affected pattern. The directed nesting cases expose faults in the special-mask and special-nesting exclusions.

// File: rtl/rpic_pkg.sv
package rpic_pkg;
    typedef struct packed {
        logic smm;    // special mask mode
        logic sfn;    // special nesting mode
        logic aeoi;   // automatic end of interrupt
        logic raeoi;  // rotate on automatic end of interrupt
    } rpic_mode_t;
endpackage

// File: rtl/rpic_prio_find.sv
module rpic_prio_find #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] base,
    output logic         found,
    output logic [W:0]   rank,   // N when nothing set
    output logic [W-1:0] line
);
    always_comb begin
        found = 1'b0;
        rank  = (W+1)'(N);
        line  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int unsigned idx;
            idx = (k + int'(base)) % N;
            if (vec[idx]) begin
                found = 1'b1;
                rank  = (W+1)'(k);
                line  = W'(idx);
            end
        end
    end

    always_comb begin
        if (found) begin
            AST_WINNER_PENDING: assert (vec[line]); // R4
        end
    end
endmodule

// File: rtl/rpic_req_capture.sv
module rpic_req_capture #(
    parameter int N = 8
) (
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] req,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] grant,
    output logic [N-1:0] req_next
);
    for (genvar i = 0; i < N; i++) begin : g_line
        always_comb begin
            if (trig[i])
                req_next[i] = irq_in[i];
            else
                req_next[i] = (req[i] & ~grant[i]) | (irq_in[i] & ~prev[i]);
        end
    end
endmodule

// File: rtl/rpic_core.sv
module rpic_core #(
    parameter int          N          = 8,
    parameter logic        IS_MASTER  = 1'b1,
    parameter int          CAS_LINE   = 2,
    parameter logic [N-1:0] TRIG_ALLOW = N'('hF8),
    localparam int         W          = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_in,
    input  logic         init,
    input  logic         mask_ld,
    input  logic [N-1:0] mask_val,
    input  logic         trig_ld,
    input  logic [N-1:0] trig_val,
    input  logic         base_ld,
    input  logic [W-1:0] base_val,
    input  logic         mode_ld,
    input  logic         mode_smm,
    input  logic         mode_sfn,
    input  logic         mode_aeoi,
    input  logic         mode_raeoi,
    input  logic         isr_clr_ld,
    input  logic [N-1:0] isr_clr_val,
    input  logic         ack,
    output logic         irq_out,
    output logic [W-1:0] ack_line,
    output logic         ack_hit,
    output logic [N-1:0] req_out,
    output logic [N-1:0] isr_out,
    output logic [N-1:0] mask_out,
    output logic [N-1:0] trig_out,
    output logic [W-1:0] base_out
);
    import rpic_pkg::*;

    localparam logic [N-1:0] CAS_BIT = N'(1) << CAS_LINE;

    typedef struct packed {
        logic [N-1:0] req;
        logic [N-1:0] prev;
        logic [N-1:0] mask;
        logic [N-1:0] isr;
        logic [N-1:0] trig;
        logic [W-1:0] base;
        rpic_mode_t   mode;
        logic         irq;
        logic [W-1:0] line;
        logic         hit;
    } rpic_state_t;

    rpic_state_t q, d;

    logic [N-1:0] cand, isr_view, grant_oh, req_next;
    logic         cand_found, isr_found, take;
    logic [W:0]   cand_rank, isr_rank;
    logic [W-1:0] cand_line, isr_line;

    assign cand     = q.req & ~q.mask;
    assign isr_view = q.isr & ~(q.mode.smm ? q.mask : '0)
                            & ~((q.mode.sfn && IS_MASTER) ? CAS_BIT : '0);

    rpic_prio_find #(.N(N)) u_cand (
        .vec(cand), .base(q.base),
        .found(cand_found), .rank(cand_rank), .line(cand_line)
    );

    rpic_prio_find #(.N(N)) u_isr (
        .vec(isr_view), .base(q.base),
        .found(isr_found), .rank(isr_rank), .line(isr_line)
    );

    assign take     = cand_found && (cand_rank < isr_rank);
    assign grant_oh = (ack && take) ? (N'(1) << cand_line) : '0;

    rpic_req_capture #(.N(N)) u_capture (
        .irq_in(irq_in), .prev(q.prev), .req(q.req), .trig(q.trig),
        .grant(grant_oh), .req_next(req_next)
    );

    always_comb begin
        d      = q;
        d.prev = irq_in;
        d.req  = req_next;
        d.irq  = take;
        if (ack) begin
            d.line = take ? cand_line : W'(N - 1);
            d.hit  = take;
        end
        if (isr_clr_ld)
            d.isr = q.isr & ~isr_clr_val;
        if (ack && take) begin
            if (!q.mode.aeoi)
                d.isr = d.isr | grant_oh;
            else if (q.mode.raeoi)
                d.base = (int'(cand_line) == N - 1) ? '0 : cand_line + W'(1);
        end
        if (base_ld) d.base = base_val;
        if (mask_ld) d.mask = mask_val;
        if (trig_ld) d.trig = trig_val & TRIG_ALLOW;
        if (mode_ld) d.mode = '{smm: mode_smm, sfn: mode_sfn,
                                aeoi: mode_aeoi, raeoi: mode_raeoi};
        if (init) begin
            d.req  = '0;
            d.prev = '0;
            d.mask = '0;
            d.isr  = '0;
            d.base = '0;
            d.mode = '0;
            d.irq  = 1'b0;
            d.line = '0;
            d.hit  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign irq_out  = q.irq;
    assign ack_line = q.line;
    assign ack_hit  = q.hit;
    assign req_out  = q.req;
    assign isr_out  = q.isr;
    assign mask_out = q.mask;
    assign trig_out = q.trig;
    assign base_out = q.base;

    AST_IRQ_NEEDS_CAND: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> $past(|(q.req & ~q.mask))); // R5

    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack && take && !q.mode.aeoi && !init) |=> |(q.isr & $past(grant_oh))); // R9

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
        !init |=> ((q.req & $past(q.trig)) == ($past(irq_in) & $past(q.trig)))); // R2

    AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (rst)
        (ack && q.mode.aeoi && !isr_clr_ld && !init) |=> $stable(q.isr)); // R10

    AST_ISR_WINNER_SET: assert property (@(posedge clk) disable iff (rst)
        isr_found |-> q.isr[isr_line]); // R6
endmodule

// File: tb/rpic_core_bench.sv
`timescale 1ns/1ps
module rpic_core_bench;
    localparam int N = 8;
    localparam int W = 3;
    localparam logic [7:0] ALLOW = 8'hF8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] irq_in = '0, mask_val = '0, trig_val = '0, isr_clr_val = '0;
    logic init = 0, mask_ld = 0, trig_ld = 0, base_ld = 0, mode_ld = 0;
    logic mode_smm = 0, mode_sfn = 0, mode_aeoi = 0, mode_raeoi = 0;
    logic isr_clr_ld = 0, ack = 0;
    logic [W-1:0] base_val = '0;
    logic irq_out, ack_hit;
    logic [W-1:0] ack_line, base_out;
    logic [N-1:0] req_out, isr_out, mask_out, trig_out;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rpic_core u_rpic_core (
        .clk(clk), .rst(rst), .irq_in(irq_in), .init(init),
        .mask_ld(mask_ld), .mask_val(mask_val),
        .trig_ld(trig_ld), .trig_val(trig_val),
        .base_ld(base_ld), .base_val(base_val),
        .mode_ld(mode_ld), .mode_smm(mode_smm), .mode_sfn(mode_sfn),
        .mode_aeoi(mode_aeoi), .mode_raeoi(mode_raeoi),
        .isr_clr_ld(isr_clr_ld), .isr_clr_val(isr_clr_val),
        .ack(ack), .irq_out(irq_out), .ack_line(ack_line), .ack_hit(ack_hit),
        .req_out(req_out), .isr_out(isr_out), .mask_out(mask_out),
        .trig_out(trig_out), .base_out(base_out)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_init();
        irq_in = '0; init = 1; tick(); init = 0;
    endtask

    task automatic set_mode(logic smm, logic sfn, logic ae, logic rae);
        mode_smm = smm; mode_sfn = sfn; mode_aeoi = ae; mode_raeoi = rae;
        mode_ld = 1; tick(); mode_ld = 0;
    endtask

    task automatic do_ack();
        ack = 1; tick(); ack = 0;
    endtask

    function automatic int model_line(logic [7:0] c, int b);
        for (int k = 0; k < N; k++)
            if (c[(k + b) % N]) return (k + b) % N;
        return -1;
    endfunction

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk); tick(); rst = 0; tick();
        // R1 reset state
        check("R1 irq", irq_out, 0);
        check("R1 req", req_out, 0);
        check("R1 isr", isr_out, 0);
        check("R1 trig", trig_out, 0);
        check("R1 base", base_out, 0);
        check("R1 hit", ack_hit, 0);

        // R12 trigger select filtered by allow mask
        trig_val = 8'hFF; trig_ld = 1; tick(); trig_ld = 0;
        check("R12 trig load", trig_out, ALLOW);

        // R2 level line follows input
        irq_in = 8'h20; tick();
        check("R2 level high", req_out[5], 1);
        irq_in = 8'h00; tick();
        check("R2 level low", req_out[5], 0);

        // R3 edge line latches rising edge
        irq_in = 8'h02; tick();
        check("R3 edge set", req_out[1], 1);
        irq_in = 8'h00; tick();
        check("R3 edge held", req_out[1], 1);

        // R12 init keeps trigger select, clears others
        mask_val = 8'h11; mask_ld = 1; tick(); mask_ld = 0;
        pulse_init();
        check("R12 init req", req_out, 0);
        check("R12 init mask", mask_out, 0);
        check("R12 init trig kept", trig_out, ALLOW);

        // R4 R5 R9 R11 R13 sweep over bases and patterns
        for (int b = 0; b < N; b++) begin
            for (int i = 0; i < 24; i++) begin
                logic [7:0] pat, msk, c;
                int exp_line;
                pat = 8'((i * 53 + 7) & 255);
                msk = (i % 2 == 1) ? 8'((i * 29 + 3) & 255) : 8'h00;
                if (i == 0) pat = 8'h00;
                c = pat & ~msk;
                exp_line = model_line(c, b);
                pulse_init();
                base_val = W'(b); base_ld = 1;
                mask_val = msk; mask_ld = 1;
                tick();
                base_ld = 0; mask_ld = 0;
                irq_in = pat; tick(); tick();
                check("R5 irq vs candidates", irq_out, (c != 0) ? 1 : 0);
                do_ack();
                if (exp_line >= 0) begin
                    check("R4 granted line", ack_line, exp_line);
                    check("R9 isr set", isr_out, 1 << exp_line);
                    check("R11 req after grant", req_out,
                          ALLOW[exp_line] ? pat : (pat & ~(8'(1) << exp_line)));
                end else begin
                    check("R13 miss hit", ack_hit, 0);
                    check("R13 miss line", ack_line, N - 1);
                    check("R13 isr untouched", isr_out, 0);
                end
            end
        end

        // R6 strict nesting and clear
        pulse_init();
        irq_in = 8'h20; tick(); tick();
        do_ack();
        check("R6 isr5", isr_out, 8'h20);
        irq_in = 8'h60; tick(); tick();
        check("R6 blocked by isr", irq_out, 0);
        irq_in = 8'h68; tick(); tick();
        check("R6 higher rank passes", irq_out, 1);
        irq_in = 8'h60; tick();
        isr_clr_val = 8'h20; isr_clr_ld = 1; tick(); isr_clr_ld = 0;
        tick();
        check("R6 cleared isr unblocks", irq_out, 1);

        // R7 special mask mode
        pulse_init();
        irq_in = 8'h20; tick(); tick();
        do_ack();
        irq_in = 8'h60;
        mask_val = 8'h20; mask_ld = 1; tick(); mask_ld = 0; tick();
        check("R7 no smm blocked", irq_out, 0);
        set_mode(1, 0, 0, 0); tick();
        check("R7 smm passes", irq_out, 1);
        do_ack();
        check("R7 smm line", ack_line, 6);

        // R8 special nesting on master
        pulse_init();
        irq_in = 8'h04; tick(); tick();
        do_ack();
        check("R8 grant line2", ack_line, 2);
        irq_in = 8'h00; tick();
        irq_in = 8'h04; tick(); tick();
        check("R8 nesting off blocked", irq_out, 0);
        set_mode(0, 1, 0, 0); tick();
        check("R8 nesting on passes", irq_out, 1);

        // R10 auto EOI with rotation
        pulse_init();
        set_mode(0, 0, 1, 1);
        irq_in = 8'h10; tick(); tick();
        do_ack();
        check("R10 rot line", ack_line, 4);
        check("R10 rot isr", isr_out, 0);
        check("R10 rot base", base_out, 5);
        check("R11 level kept", req_out[4], 1);
        // R10 auto EOI without rotation
        pulse_init();
        set_mode(0, 0, 1, 0);
        irq_in = 8'h80; tick(); tick();
        do_ack();
        check("R10 plain line", ack_line, 7);
        check("R10 plain isr", isr_out, 0);
        check("R10 plain base", base_out, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule